// File: doc/BRIEF.md
# Synchronous Memory Boot Configuration Sequencer

This block sits ahead of a single-data-rate synchronous memory controller with four chip-select banks, each with its own configuration byte. When power-on reset ends, it reads two strap pins. If they call for booting from a synchronous ROM or a synchronous flash, it programs the boot bank before letting the processor run. The sequence is a precharge of all banks, then a mode-register load, then a fixed settling wait. At the same moment as the mode-register load, it fills in the boot bank's configuration byte. The processor reset output stays asserted until the sequence is complete.

After the boot phase, the block issues auto-refresh commands at a fixed interval. A soft reset asserts only the processor reset output. The refresh schedule and the configuration bytes carry on as before, so the memory contents survive. Only power-on reset clears them. The memory clock enable is held low whenever the memory reports idle and no command is being presented.

Top module: `memboot_seq`

## Requirements
- R1: The straps are sampled once, at the first clock edge after power-on reset is released. `strapBoot` = 2'b01 selects ROM boot, 2'b10 selects flash boot, and 2'b00 or 2'b11 selects no synchronous boot. Changing the straps later has no effect.
- R2: Commands on `memCmd` are encoded as {csN, rasN, casN, weN}: NOP = 4'b0111, precharge = 4'b0010, mode set = 4'b0000, auto-refresh = 4'b0001.
  - On a synchronous boot, `memCmd` shows precharge with `memAddr` = 13'h400 (bit 10 set, meaning all banks) during the cycle after the first edge.
  - `memCmd` shows mode set during the following cycle.
- R3: During mode set, `memAddr` carries:
  - bits 2:0 = 3'b010 (burst length 4);
  - bit 3 = 0 (sequential burst);
  - bits 6:4 = CAS latency 5;
  - bits 8:7 = RAS latency 2;
  - all other bits 0.
  This gives 13'h152.
- R4: On the mode-set edge, the boot bank (bank 3) configuration byte is loaded with these fields:
  - bit 7 = valid (1);
  - bit 6 = ROM (set only for a ROM boot);
  - bit 5 = `strapWide` (1 = 32-bit bus, 0 = 16-bit bus);
  - bits 4:3 = RAS latency 2;
  - bits 2:0 = CAS latency 5.
  This gives 8'hD5 or 8'hF5 for ROM and 8'h95 or 8'hB5 for flash. Bank b occupies `bankCfg[8b+7:8b]`, and the banks that are not booted stay 0.
- R5: On a synchronous boot, `cpuRstN` goes high at the 7th edge after release, which is 4 wait cycles after the mode-set cycle. With no synchronous boot, it goes high at the 1st edge and no command is issued.
- R6: While power-on reset is asserted, the outputs are:
  - `memCmd` = NOP;
  - `memAddr` = 0;
  - `memCke` = 0;
  - `cpuRstN` = 0;
  - `bankCfg` = 0.
- R7: Once the sequence is done, an auto-refresh command appears exactly every 64 cycles.
- R8: Soft reset has these effects:
  - `cpuRstN` goes low one edge after `softRstN` falls;
  - `cpuRstN` goes high one edge after `softRstN` rises;
  - refresh continues throughout;
  - `bankCfg` is unchanged;
  - the boot sequence does not run again.
- R9: `memCke` is 1 in every cycle that carries a command. In all other cycles it equals the inverse of `memIdle`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| porRstN | input | 1 | Power-on reset, active low, asynchronous |
| softRstN | input | 1 | Soft reset, active low |
| strapBoot | input | 2 | Boot source straps |
| strapWide | input | 1 | Bus width strap (1 = 32-bit) |
| memIdle | input | 1 | Memory is idle, allowing clock enable to drop |
| memCmd | output | 4 | {csN, rasN, casN, weN} command |
| memAddr | output | 13 | Address bus value presented with the command |
| memCke | output | 1 | Memory clock enable |
| bankCfg | output | 32 | Four packed bank configuration bytes |
| cpuRstN | output | 1 | Processor reset release, active low |

## Verification
The hardest situation to reach is a soft reset held long enough to span refresh intervals. During it, memory state must be untouched while the processor stays in reset. The bench reaches this by completing a ROM boot and first measuring the refresh period. It then holds `softRstN` low for well over two refresh periods. Throughout that window it counts refreshes, watches for any precharge or mode-set command, and compares the configuration bytes against their values before the soft reset. A strap change made after boot is checked the same way, through `bankCfg`.

// File: rtl/memboot_pkg.sv
package memboot_pkg;

  typedef enum logic [2:0] {
    S_START,
    S_PRE,
    S_MRS,
    S_WAIT,
    S_DONE
  } seq_state_t;

  // {csN, rasN, casN, weN}
  localparam logic [3:0] CMD_NOP  = 4'b0111;
  localparam logic [3:0] CMD_PRE  = 4'b0010;
  localparam logic [3:0] CMD_MRS  = 4'b0000;
  localparam logic [3:0] CMD_AREF = 4'b0001;

  localparam logic [1:0] BOOT_ROM   = 2'b01;
  localparam logic [1:0] BOOT_FLASH = 2'b10;

  localparam int CFG_W = 8;

  typedef struct packed {
    logic sampleStrap;
    logic doPre;
    logic doMrs;
    logic doRefresh;
  } seq_strobe_t;

  function automatic logic [CFG_W-1:0] makeCfg(logic isRom, logic isWide,
                                               logic [1:0] ras, logic [2:0] cas);
    return {1'b1, isRom, isWide, ras, cas};
  endfunction

endpackage

// File: rtl/memboot_ctrl.sv
module memboot_ctrl
  import memboot_pkg::*;
#(
  parameter int WAIT_CYC = 4
) (
  input  logic        clk,
  input  logic        porRstN,
  input  logic        softRstN,
  input  logic [1:0]  strapBoot,
  input  logic        refreshDue,
  output seq_strobe_t strb,
  output logic        cpuRstN
);

  localparam int WCW = $clog2(WAIT_CYC + 1);

  seq_state_t     state, stateNext;
  logic [WCW-1:0] waitCnt;
  logic           bootSync;

  assign bootSync = (strapBoot == BOOT_ROM) || (strapBoot == BOOT_FLASH);

  always_comb begin
    stateNext = state;
    case (state)
      S_START: stateNext = bootSync ? S_PRE : S_DONE;
      S_PRE:   stateNext = S_MRS;
      S_MRS:   stateNext = S_WAIT;
      S_WAIT:  if (waitCnt == WCW'(WAIT_CYC - 1)) stateNext = S_DONE;
      S_DONE:  stateNext = S_DONE;
      default: stateNext = S_START;
    endcase
  end

  always_comb begin
    strb.sampleStrap = (state == S_START);
    strb.doPre       = (state == S_START) && (stateNext == S_PRE);
    strb.doMrs       = (state == S_PRE) && (stateNext == S_MRS);
    strb.doRefresh   = (state == S_DONE) && refreshDue;
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      state   <= S_START;
      waitCnt <= '0;
      cpuRstN <= 1'b0;
    end else begin
      state   <= stateNext;
      waitCnt <= (state == S_WAIT) ? waitCnt + 1'b1 : '0;
      cpuRstN <= (stateNext == S_DONE) && softRstN;
    end
  end

  // R2: precharge is always followed by mode set, then the wait
  assert_pre_then_mrs_R2: assert property (@(posedge clk) disable iff (!porRstN)
    state == S_PRE |=> state == S_MRS);
  assert_mrs_then_wait_R5: assert property (@(posedge clk) disable iff (!porRstN)
    state == S_MRS |=> state == S_WAIT);
  // R5: processor is released only once the sequence is finished
  assert_release_done_R5: assert property (@(posedge clk) disable iff (!porRstN)
    cpuRstN |-> state == S_DONE);
  // R8: soft reset holds the processor at the following edge
  assert_soft_hold_R8: assert property (@(posedge clk) disable iff (!porRstN)
    !softRstN |=> !cpuRstN);
  // R2: at most one command strobe per cycle
  assert_one_cmd_R2: assert property (@(posedge clk) disable iff (!porRstN)
    $onehot0({strb.doPre, strb.doMrs, strb.doRefresh}));

endmodule

// File: rtl/memboot_dp.sv
module memboot_dp
  import memboot_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BOOT_BANK = 3,
  parameter int ADDR_W    = 13,
  parameter int REF_INT   = 64,
  parameter int RAS_LAT   = 2,
  parameter int CAS_LAT   = 5,
  parameter int BURST_LEN = 4
) (
  input  logic                       clk,
  input  logic                       porRstN,
  input  seq_strobe_t                strb,
  input  logic [1:0]                 strapBoot,
  input  logic                       strapWide,
  input  logic                       memIdle,
  output logic [3:0]                 memCmd,
  output logic [ADDR_W-1:0]          memAddr,
  output logic                       memCke,
  output logic [NUM_BANKS*CFG_W-1:0] bankCfg,
  output logic                       refreshDue
);

  localparam int RCW = $clog2(REF_INT);
  localparam logic [ADDR_W-1:0] MODE_VAL =
    ADDR_W'({2'(RAS_LAT), 3'(CAS_LAT), 1'b0, 3'($clog2(BURST_LEN))});
  localparam logic [ADDR_W-1:0] PRE_ALL_VAL = ADDR_W'(1024);

  logic           romLatch, wideLatch;
  logic [RCW-1:0] refCnt;
  logic           refWrap, anyCmd;

  // Strap capture
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      romLatch  <= 1'b0;
      wideLatch <= 1'b0;
    end else if (strb.sampleStrap) begin
      romLatch  <= (strapBoot == BOOT_ROM);
      wideLatch <= strapWide;
    end
  end

  // Refresh interval timer, cleared only by power-on reset
  assign refWrap = (refCnt == RCW'(REF_INT - 1));

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      refCnt     <= '0;
      refreshDue <= 1'b0;
    end else begin
      refCnt <= refWrap ? '0 : refCnt + 1'b1;
      if (refWrap)             refreshDue <= 1'b1;
      else if (strb.doRefresh) refreshDue <= 1'b0;
    end
  end

  // Command, address and clock enable registers
  assign anyCmd = strb.doPre | strb.doMrs | strb.doRefresh;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      memCmd  <= CMD_NOP;
      memAddr <= '0;
      memCke  <= 1'b0;
    end else begin
      if (strb.doPre)          memCmd <= CMD_PRE;
      else if (strb.doMrs)     memCmd <= CMD_MRS;
      else if (strb.doRefresh) memCmd <= CMD_AREF;
      else                     memCmd <= CMD_NOP;
      memAddr <= strb.doPre ? PRE_ALL_VAL : (strb.doMrs ? MODE_VAL : '0);
      memCke  <= anyCmd | ~memIdle;
    end
  end

  // Bank configuration bytes
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [CFG_W-1:0] cfgQ;
    if (b == BOOT_BANK) begin : g_boot
      always_ff @(posedge clk or negedge porRstN) begin
        if (!porRstN)       cfgQ <= '0;
        else if (strb.doMrs) cfgQ <= makeCfg(romLatch, wideLatch, 2'(RAS_LAT), 3'(CAS_LAT));
      end
    end else begin : g_plain
      assign cfgQ = '0;
    end
    assign bankCfg[b*CFG_W +: CFG_W] = cfgQ;
  end

  // R3: mode set always carries the mode word
  assert_mode_word_R3: assert property (@(posedge clk) disable iff (!porRstN)
    memCmd == CMD_MRS |-> memAddr == MODE_VAL);
  // R9: any command is presented with the clock enabled
  assert_cke_cmd_R9: assert property (@(posedge clk) disable iff (!porRstN)
    memCmd != CMD_NOP |-> memCke);
  // R4 / R8: configuration changes only together with mode set
  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!porRstN)
    !$stable(bankCfg) |-> memCmd == CMD_MRS);
  // R7: a refresh never repeats on consecutive cycles
  assert_refresh_single_R7: assert property (@(posedge clk) disable iff (!porRstN)
    memCmd == CMD_AREF |=> memCmd != CMD_AREF);

endmodule

// File: rtl/memboot_seq.sv
module memboot_seq
  import memboot_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BOOT_BANK = 3,
  parameter int ADDR_W    = 13,
  parameter int WAIT_CYC  = 4,
  parameter int REF_INT   = 64,
  parameter int RAS_LAT   = 2,
  parameter int CAS_LAT   = 5,
  parameter int BURST_LEN = 4
) (
  input  logic                       clk,
  input  logic                       porRstN,
  input  logic                       softRstN,
  input  logic [1:0]                 strapBoot,
  input  logic                       strapWide,
  input  logic                       memIdle,
  output logic [3:0]                 memCmd,
  output logic [ADDR_W-1:0]          memAddr,
  output logic                       memCke,
  output logic [NUM_BANKS*CFG_W-1:0] bankCfg,
  output logic                       cpuRstN
);

  seq_strobe_t strb;
  logic        refreshDue;

  memboot_ctrl #(.WAIT_CYC(WAIT_CYC)) u_ctrl (
    .clk       (clk),
    .porRstN   (porRstN),
    .softRstN  (softRstN),
    .strapBoot (strapBoot),
    .refreshDue(refreshDue),
    .strb      (strb),
    .cpuRstN   (cpuRstN)
  );

  memboot_dp #(
    .NUM_BANKS(NUM_BANKS),
    .BOOT_BANK(BOOT_BANK),
    .ADDR_W   (ADDR_W),
    .REF_INT  (REF_INT),
    .RAS_LAT  (RAS_LAT),
    .CAS_LAT  (CAS_LAT),
    .BURST_LEN(BURST_LEN)
  ) u_dp (
    .clk       (clk),
    .porRstN   (porRstN),
    .strb      (strb),
    .strapBoot (strapBoot),
    .strapWide (strapWide),
    .memIdle   (memIdle),
    .memCmd    (memCmd),
    .memAddr   (memAddr),
    .memCke    (memCke),
    .bankCfg   (bankCfg),
    .refreshDue(refreshDue)
  );

endmodule

// File: tb/memboot_seq_test.sv
`timescale 1ns/1ps
module memboot_seq_test;

  localparam logic [3:0] NOP  = 4'b0111;
  localparam logic [3:0] PRE  = 4'b0010;
  localparam logic [3:0] MRS  = 4'b0000;
  localparam logic [3:0] AREF = 4'b0001;
  localparam int NVEC = 6;
  // {strap[1:0], wide, expected bank3 byte, expected release edge}
  localparam logic [18:0] VEC [NVEC] = '{
    {2'b00, 1'b0, 8'h00, 8'd1},
    {2'b01, 1'b0, 8'hD5, 8'd7},
    {2'b01, 1'b1, 8'hF5, 8'd7},
    {2'b10, 1'b0, 8'h95, 8'd7},
    {2'b10, 1'b1, 8'hB5, 8'd7},
    {2'b11, 1'b1, 8'h00, 8'd1}
  };

  logic        clk = 1'b0;
  logic        porRstN = 1'b0, softRstN = 1'b1, strapWide = 1'b0, memIdle = 1'b1;
  logic [1:0]  strapBoot = 2'b00;
  logic [3:0]  memCmd;
  logic [12:0] memAddr;
  logic        memCke, cpuRstN;
  logic [31:0] bankCfg;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  memboot_seq uut (
    .clk(clk), .porRstN(porRstN), .softRstN(softRstN), .strapBoot(strapBoot),
    .strapWide(strapWide), .memIdle(memIdle), .memCmd(memCmd), .memAddr(memAddr),
    .memCke(memCke), .bankCfg(bankCfg), .cpuRstN(cpuRstN)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] cfgSaved;
    int lastRef, nRef, nBad, relEdge;

    // Table walk: one power-on boot per vector
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] st;
      logic       wd, boot;
      logic [7:0] eCfg, eRel;
      {st, wd, eCfg, eRel} = VEC[v];
      boot = (st == 2'b01) || (st == 2'b10);
      @(negedge clk);
      porRstN = 1'b0; strapBoot = st; strapWide = wd; memIdle = 1'b1; softRstN = 1'b1;
      repeat (3) @(negedge clk);
      chk("R6 cmd", 32'(memCmd), 32'(NOP));
      chk("R6 cke", 32'(memCke), 0);
      chk("R6 cpuRstN", 32'(cpuRstN), 0);
      chk("R6 cfg", bankCfg, 0);
      chk("R6 addr", 32'(memAddr), 0);
      porRstN = 1'b1;
      relEdge = 0;
      for (int e = 1; e <= 12; e++) begin
        step();
        if (relEdge == 0 && cpuRstN) relEdge = e;
        if (e == 1) begin
          chk("R2 first cmd", 32'(memCmd), boot ? 32'(PRE) : 32'(NOP));
          if (boot) chk("R2 precharge-all addr", 32'(memAddr), 32'h400);
        end
        if (e == 2) begin
          chk("R2 second cmd", 32'(memCmd), boot ? 32'(MRS) : 32'(NOP));
          if (boot) begin
            chk("R3 mode word", 32'(memAddr), 32'h152);
            chk("R9 cke on command", 32'(memCke), 1);
          end
        end
        if (e >= 3) chk("R5 no further commands", 32'(memCmd), 32'(NOP));
      end
      chk("R5 release edge", 32'(relEdge), 32'(eRel));
      chk("R4 bank3 cfg", 32'(bankCfg[31:24]), 32'(eCfg));
      chk("R4 other banks", 32'(bankCfg[23:0]), 0);
      // R1: later strap changes ignored
      @(negedge clk);
      strapBoot = ~st; strapWide = ~wd;
      repeat (3) step();
      chk("R1 strap ignored after boot", 32'(bankCfg[31:24]), 32'(eCfg));
    end

    // Directed: ROM boot, then refresh period and clock enable
    @(negedge clk);
    porRstN = 1'b0; strapBoot = 2'b01; strapWide = 1'b1; memIdle = 1'b1;
    repeat (2) @(negedge clk);
    porRstN = 1'b1;
    repeat (10) step();
    chk("R9 cke low when idle", 32'(memCke), 0);
    lastRef = -1; nRef = 0;
    for (int c = 0; c < 200; c++) begin
      step();
      if (memCmd == AREF) begin
        chk("R9 cke during refresh", 32'(memCke), 1);
        if (lastRef >= 0) chk("R7 refresh interval", 32'(c - lastRef), 64);
        lastRef = c; nRef++;
      end
    end
    chk("R7 refresh count", 32'(nRef >= 2), 1);
    @(negedge clk);
    memIdle = 1'b0;
    step();
    chk("R9 cke follows busy", 32'(memCke), 1);
    @(negedge clk);
    memIdle = 1'b1;

    // Directed: soft reset spanning refreshes
    cfgSaved = bankCfg;
    @(negedge clk);
    softRstN = 1'b0;
    step();
    chk("R8 cpuRstN low on soft reset", 32'(cpuRstN), 0);
    nRef = 0; nBad = 0;
    for (int c = 0; c < 150; c++) begin
      step();
      if (memCmd == AREF) nRef++;
      if (memCmd == PRE || memCmd == MRS) nBad++;
    end
    chk("R8 refresh continues", 32'(nRef >= 2), 1);
    chk("R8 no boot commands", 32'(nBad), 0);
    chk("R8 cfg kept", bankCfg, cfgSaved);
    @(negedge clk);
    softRstN = 1'b1;
    step();
    chk("R8 cpuRstN released", 32'(cpuRstN), 1);
    nBad = 0;
    for (int c = 0; c < 10; c++) begin
      step();
      if (memCmd == PRE || memCmd == MRS) nBad++;
    end
    chk("R8 no rerun after soft reset", 32'(nBad), 0);
    chk("R8 cfg kept after release", bankCfg, cfgSaved);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule